// File: doc/BRIEF.md
# Dominant Eigenvector of Z·Z^H by Power Iteration

This block turns a 16-element complex vector into a 4-element complex beamforming vector. The vector is loaded word by word into the block and read as the columns of a 4×4 complex matrix Z. After a start pulse the block forms the Hermitian product A = Z·Z^H. It then estimates the dominant eigenvector of A with a fixed number of power-method steps. The four result words can be read back through a small addressed read port.

All data at the edges is complex, with signed 8-bit real and imaginary parts. Internally the arithmetic is wider fixed point and runs on one complex multiply-accumulate unit that is shared by every phase. No divider and no square root are used. Between iterations the vector is kept in range by power-of-two shifts. At the end it is shifted so that its largest part sits in the upper half of the 8-bit range.

A run takes a fixed 154 cycles. The result stays readable until the next run overwrites it.

Top module: `zzh_eigvec`

## Requirements
- R1: After reset, busy and done are low, and every output word reads 0 + 0i.
- R2: While idle, a cycle with in_we high stores (in_re, in_im) at element in_addr (0..15). Element k is entry (row k mod 4, column k div 4) of Z, so elements 0..3 form column 0. A write in the same cycle as start is included in that run.
- R3: The block forms A(r,s) = sum over c of Z(r,c)·conj(Z(s,c)) exactly, in full integer precision.
- R4: The power method starts from v = (1,1,1,1) with zero imaginary parts. It performs exactly 5 products u = A·v, and each product is followed by the rescale of R5.
- R5: Each rescale takes M = the largest of |Re| and |Im| over the four elements of u, and p = the index of the highest set bit of M (p = 0 when M = 0). Every part is shifted by p − 13: an arithmetic right shift with floor when this is positive, an exact left shift otherwise. Every part of the result therefore lies in [−16384, 16383].
- R6: The output takes M and p in the same way from the final vector, with k = p − 6. For k ≤ 0 each part is shifted left by −k. For k > 0 each part becomes floor((x + 2^(k−1)) / 2^k). Each part is then saturated to [−128, 127]. An all-zero result reads as zeros.
- R7: busy is high for exactly 154 cycles, starting in the cycle after start is sampled while idle. done is high only in the last of those cycles, which is one cycle after the final output word is written.
- R8: While busy, start and in_we have no effect. The running result and the stored input elements are unchanged, so a later run without new writes gives the same result.
- R9: out_re/out_im show output word out_addr (0..3) combinationally. The words hold their values until the next run writes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when sampled while idle |
| in_we | input | 1 | Writes one input element while idle |
| in_addr | input | 4 | Input element index |
| in_re | input | 8 | Real part of the input element, signed |
| in_im | input | 8 | Imaginary part of the input element, signed |
| out_addr | input | 2 | Output word index |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| out_re | output | 8 | Real part of the selected output word, signed |
| out_im | output | 8 | Imaginary part of the selected output word, signed |

## Verification
The assertions watch the handshake on every cycle. They check that done is a single-cycle pulse inside busy that directly follows the output-writing phase, and that busy only rises after a start. They also check that the stored inputs stay frozen while busy, that the output words do not move while idle, and that the iterated vector never leaves the 15-bit range the rescale promises. The exact numeric results can only be shown by the bench scenarios, where a behavioural model recomputes Z·Z^H, the five rescaled products and the final rounding. These scenarios cover single nonzero elements at chosen positions (which expose the column-wise reshape), random complex vectors, full-scale negative inputs, tiny and all-zero inputs, and writes and starts issued during a run.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [2:0] {
        PS_IDLE = 3'd0,
        PS_GRAM = 3'd1,
        PS_ITER = 3'd2,
        PS_NORM = 3'd3,
        PS_OUT  = 3'd4,
        PS_FIN  = 3'd5
    } pm_state_e;

endpackage

// File: rtl/pm_cmac.sv
module pm_cmac #(
    parameter int OW    = 20,
    parameter int ACC_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic                    conj_b,
    input  logic signed [OW-1:0]    a_re,
    input  logic signed [OW-1:0]    a_im,
    input  logic signed [OW-1:0]    b_re,
    input  logic signed [OW-1:0]    b_im,
    output logic signed [ACC_W-1:0] sum_re,
    output logic signed [ACC_W-1:0] sum_im
);

    typedef struct packed {
        logic signed [ACC_W-1:0] re;
        logic signed [ACC_W-1:0] im;
    } acc_t;

    acc_t acc_q, acc_d;

    logic signed [ACC_W-1:0] ar, ai, br, bi, pr, pi;

    always_comb begin
        ar = ACC_W'(a_re);
        ai = ACC_W'(a_im);
        br = ACC_W'(b_re);
        bi = conj_b ? -ACC_W'(b_im) : ACC_W'(b_im);
        pr = ar * br - ai * bi;
        pi = ar * bi + ai * br;
        sum_re = first ? pr : acc_q.re + pr;
        sum_im = first ? pi : acc_q.im + pi;
        acc_d = acc_q;
        if (en) begin
            acc_d.re = sum_re;
            acc_d.im = sum_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

endmodule

// File: rtl/pm_lead.sv
module pm_lead #(
    parameter int W  = 48,
    parameter int N  = 4,
    parameter int PW = 6
) (
    input  logic [N-1:0][W-1:0] vr,
    input  logic [N-1:0][W-1:0] vi,
    output logic [PW-1:0]       pos
);

    logic [W-1:0] mx, mr, mi;

    always_comb begin
        mx = '0;
        mr = '0;
        mi = '0;
        for (int k = 0; k < N; k++) begin
            mr = vr[k][W-1] ? -vr[k] : vr[k];
            mi = vi[k][W-1] ? -vi[k] : vi[k];
            if (mr > mx) mx = mr;
            if (mi > mx) mx = mi;
        end
        pos = '0;
        for (int b = 0; b < W; b++) begin
            if (mx[b]) pos = PW'(b);
        end
    end

endmodule

// File: rtl/pm_oscale.sv
module pm_oscale #(
    parameter int W  = 16,
    parameter int DW = 8,
    parameter int SW = 8
) (
    input  logic signed [W-1:0]  x,
    input  logic signed [SW-1:0] k,
    output logic signed [DW-1:0] y
);

    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] Y_MAX = XW'((2 ** (DW - 1)) - 1);
    localparam logic signed [XW-1:0] Y_MIN = XW'(-(2 ** (DW - 1)));

    logic signed [XW-1:0] xe, t;
    logic [SW-1:0]        amt;

    always_comb begin
        xe = XW'(x);
        if (k > 0) begin
            amt = SW'(k);
            t   = (xe + (XW'(1) <<< (amt - SW'(1)))) >>> amt;
        end else begin
            amt = SW'(-k);
            t   = xe <<< amt;
        end
        if (t > Y_MAX)      y = Y_MAX[DW-1:0];
        else if (t < Y_MIN) y = Y_MIN[DW-1:0];
        else                y = t[DW-1:0];
    end

endmodule

// File: rtl/zzh_eigvec.sv
module zzh_eigvec #(
    parameter int DW     = 8,
    parameter int DIM    = 4,
    parameter int N_ITER = 5,
    parameter int VW     = 16,
    parameter int AW     = 20,
    parameter int ACC_W  = 48,
    parameter int SW     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          in_we,
    input  logic [$clog2(DIM*DIM)-1:0]    in_addr,
    input  logic signed [DW-1:0]          in_re,
    input  logic signed [DW-1:0]          in_im,
    input  logic [$clog2(DIM)-1:0]        out_addr,
    output logic                          busy,
    output logic                          done,
    output logic signed [DW-1:0]          out_re,
    output logic signed [DW-1:0]          out_im
);
    import pm_pkg::*;

    localparam int NEL   = DIM * DIM;
    localparam int CW    = $clog2(DIM);
    localparam int ITW   = $clog2(N_ITER + 1);
    localparam int PW    = $clog2(ACC_W);
    localparam int V_TOP = VW - 3;
    localparam int O_TOP = DW - 2;
    localparam int V_MAX = (2 ** (VW - 2)) - 1;
    localparam int V_MIN = -(2 ** (VW - 2));

    typedef struct packed {
        pm_state_e                  st;
        logic [CW-1:0]              i;
        logic [CW-1:0]              j;
        logic [CW-1:0]              c;
        logic [ITW-1:0]             it;
        logic                       done;
        logic [NEL-1:0][DW-1:0]     xr;
        logic [NEL-1:0][DW-1:0]     xi;
        logic [NEL-1:0][AW-1:0]     ar;
        logic [NEL-1:0][AW-1:0]     ai;
        logic [DIM-1:0][ACC_W-1:0]  ur;
        logic [DIM-1:0][ACC_W-1:0]  ui;
        logic [DIM-1:0][VW-1:0]     vr;
        logic [DIM-1:0][VW-1:0]     vi;
        logic [DIM-1:0][DW-1:0]     o_re;
        logic [DIM-1:0][DW-1:0]     o_im;
    } core_t;

    core_t q, d;

    logic                      mac_en, mac_first, mac_conj;
    logic signed [AW-1:0]      mac_ar, mac_ai, mac_br, mac_bi;
    logic signed [ACC_W-1:0]   mac_sr, mac_si;
    logic [DIM-1:0][ACC_W-1:0] lead_r, lead_i;
    logic [PW-1:0]             lead_pos;
    logic signed [SW-1:0]      out_k;
    logic signed [DW-1:0]      osc_re, osc_im;
    logic signed [ACC_W-1:0]   nr_tmp, ni_tmp;
    int                        norm_sh;

    pm_cmac #(.OW(AW), .ACC_W(ACC_W)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (mac_en),
        .first  (mac_first),
        .conj_b (mac_conj),
        .a_re   (mac_ar),
        .a_im   (mac_ai),
        .b_re   (mac_br),
        .b_im   (mac_bi),
        .sum_re (mac_sr),
        .sum_im (mac_si)
    );

    pm_lead #(.W(ACC_W), .N(DIM), .PW(PW)) u_lead (
        .vr  (lead_r),
        .vi  (lead_i),
        .pos (lead_pos)
    );

    pm_oscale #(.W(VW), .DW(DW), .SW(SW)) u_osc_re (
        .x (q.vr[q.i]),
        .k (out_k),
        .y (osc_re)
    );

    pm_oscale #(.W(VW), .DW(DW), .SW(SW)) u_osc_im (
        .x (q.vi[q.i]),
        .k (out_k),
        .y (osc_im)
    );

    // operand selection for the shared MAC and the magnitude scanner
    always_comb begin
        mac_en    = 1'b0;
        mac_first = 1'b0;
        mac_conj  = 1'b0;
        mac_ar    = '0;
        mac_ai    = '0;
        mac_br    = '0;
        mac_bi    = '0;
        for (int k = 0; k < DIM; k++) begin
            lead_r[k] = (q.st == PS_OUT) ? ACC_W'($signed(q.vr[k])) : q.ur[k];
            lead_i[k] = (q.st == PS_OUT) ? ACC_W'($signed(q.vi[k])) : q.ui[k];
        end
        out_k = SW'(int'(lead_pos) - O_TOP);
        if (q.st == PS_GRAM) begin
            mac_en    = 1'b1;
            mac_conj  = 1'b1;
            mac_first = (q.c == '0);
            mac_ar    = AW'($signed(q.xr[{q.c, q.i}]));
            mac_ai    = AW'($signed(q.xi[{q.c, q.i}]));
            mac_br    = AW'($signed(q.xr[{q.c, q.j}]));
            mac_bi    = AW'($signed(q.xi[{q.c, q.j}]));
        end else if (q.st == PS_ITER) begin
            mac_en    = 1'b1;
            mac_first = (q.j == '0);
            mac_ar    = $signed(q.ar[{q.i, q.j}]);
            mac_ai    = $signed(q.ai[{q.i, q.j}]);
            mac_br    = AW'($signed(q.vr[q.j]));
            mac_bi    = AW'($signed(q.vi[q.j]));
        end
    end

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        norm_sh = int'(lead_pos) - V_TOP;
        nr_tmp  = '0;
        ni_tmp  = '0;
        case (q.st)
            PS_IDLE: begin
                if (in_we) begin
                    d.xr[in_addr] = in_re;
                    d.xi[in_addr] = in_im;
                end
                if (start) begin
                    d.st = PS_GRAM;
                    d.i  = '0;
                    d.j  = '0;
                    d.c  = '0;
                    d.it = '0;
                    for (int k = 0; k < DIM; k++) begin
                        d.vr[k] = VW'(1);
                        d.vi[k] = '0;
                    end
                end
            end
            PS_GRAM: begin
                d.c = q.c + CW'(1);
                if (q.c == CW'(DIM - 1)) begin
                    d.ar[{q.i, q.j}] = mac_sr[AW-1:0];
                    d.ai[{q.i, q.j}] = mac_si[AW-1:0];
                    d.j = q.j + CW'(1);
                    if (q.j == CW'(DIM - 1)) begin
                        d.i = q.i + CW'(1);
                        if (q.i == CW'(DIM - 1)) d.st = PS_ITER;
                    end
                end
            end
            PS_ITER: begin
                d.j = q.j + CW'(1);
                if (q.j == CW'(DIM - 1)) begin
                    d.ur[q.i] = mac_sr;
                    d.ui[q.i] = mac_si;
                    d.i = q.i + CW'(1);
                    if (q.i == CW'(DIM - 1)) d.st = PS_NORM;
                end
            end
            PS_NORM: begin
                for (int k = 0; k < DIM; k++) begin
                    if (norm_sh > 0) begin
                        nr_tmp = $signed(q.ur[k]) >>> norm_sh;
                        ni_tmp = $signed(q.ui[k]) >>> norm_sh;
                    end else begin
                        nr_tmp = $signed(q.ur[k]) <<< (-norm_sh);
                        ni_tmp = $signed(q.ui[k]) <<< (-norm_sh);
                    end
                    d.vr[k] = nr_tmp[VW-1:0];
                    d.vi[k] = ni_tmp[VW-1:0];
                end
                d.it = q.it + ITW'(1);
                d.i  = '0;
                d.j  = '0;
                d.st = (q.it == ITW'(N_ITER - 1)) ? PS_OUT : PS_ITER;
            end
            PS_OUT: begin
                d.o_re[q.i] = osc_re;
                d.o_im[q.i] = osc_im;
                d.i = q.i + CW'(1);
                if (q.i == CW'(DIM - 1)) begin
                    d.st   = PS_FIN;
                    d.done = 1'b1;
                end
            end
            PS_FIN:  d.st = PS_IDLE;
            default: d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = (q.st != PS_IDLE);
    assign done   = q.done;
    assign out_re = q.o_re[out_addr];
    assign out_im = q.o_im[out_addr];

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_DONE_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(q.st) == PS_OUT); // R7
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R7
    AST_INPUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && in_we) |=> ($stable(q.xr) && $stable(q.xi))); // R8
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> ($stable(q.o_re) && $stable(q.o_im))); // R9

    for (genvar gk = 0; gk < DIM; gk++) begin : g_vchk
        AST_V_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (q.st == PS_ITER) |-> ($signed(q.vr[gk]) <= V_MAX && $signed(q.vr[gk]) >= V_MIN && $signed(q.vi[gk]) <= V_MAX && $signed(q.vi[gk]) >= V_MIN)); // R5
    end

endmodule

// File: tb/tb_zzh_eigvec.sv
module tb_zzh_eigvec;

    localparam int LAT = 4 * 4 * 4 + 5 * (16 + 1) + 4 + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              in_we = 1'b0;
    logic [3:0]        in_addr = '0;
    logic signed [7:0] in_re = '0;
    logic signed [7:0] in_im = '0;
    logic [1:0]        out_addr = '0;
    logic              busy, done;
    logic signed [7:0] out_re, out_im;

    zzh_eigvec dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_we(in_we),
        .in_addr(in_addr), .in_re(in_re), .in_im(in_im),
        .out_addr(out_addr), .busy(busy), .done(done),
        .out_re(out_re), .out_im(out_im)
    );

    always #5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    int mem_re[16], mem_im[16];
    int stim_re[16], stim_im[16];
    int m_out_re[4], m_out_im[4], nxt_re[4], nxt_im[4];
    bit m_busy = 0, m_done = 0;
    int m_cnt = 0;

    function automatic int lead_bit(longint m);
        int p = 0;
        for (int b = 0; b < 63; b++) if (((m >> b) & 64'sd1) != 0) p = b;
        return p;
    endfunction

    function automatic longint mag(longint x);
        return (x < 0) ? -x : x;
    endfunction

    task automatic compute_ref();
        longint ar[4][4], ai[4][4];
        longint vr[4], vi[4], ur[4], ui[4];
        longint m, t;
        int     sh;
        for (int r = 0; r < 4; r++)
            for (int s = 0; s < 4; s++) begin
                ar[r][s] = 0; ai[r][s] = 0;
                for (int c = 0; c < 4; c++) begin
                    ar[r][s] += longint'(mem_re[c*4+r]) * mem_re[c*4+s] + longint'(mem_im[c*4+r]) * mem_im[c*4+s];
                    ai[r][s] += longint'(mem_im[c*4+r]) * mem_re[c*4+s] - longint'(mem_re[c*4+r]) * mem_im[c*4+s];
                end
            end
        for (int k = 0; k < 4; k++) begin vr[k] = 1; vi[k] = 0; end
        for (int it = 0; it < 5; it++) begin
            m = 0;
            for (int r = 0; r < 4; r++) begin
                ur[r] = 0; ui[r] = 0;
                for (int s = 0; s < 4; s++) begin
                    ur[r] += ar[r][s] * vr[s] - ai[r][s] * vi[s];
                    ui[r] += ar[r][s] * vi[s] + ai[r][s] * vr[s];
                end
                if (mag(ur[r]) > m) m = mag(ur[r]);
                if (mag(ui[r]) > m) m = mag(ui[r]);
            end
            sh = lead_bit(m) - 13;
            for (int r = 0; r < 4; r++) begin
                vr[r] = (sh > 0) ? (ur[r] >>> sh) : (ur[r] <<< (-sh));
                vi[r] = (sh > 0) ? (ui[r] >>> sh) : (ui[r] <<< (-sh));
            end
        end
        m = 0;
        for (int r = 0; r < 4; r++) begin
            if (mag(vr[r]) > m) m = mag(vr[r]);
            if (mag(vi[r]) > m) m = mag(vi[r]);
        end
        sh = lead_bit(m) - 6;
        for (int r = 0; r < 4; r++) begin
            for (int part = 0; part < 2; part++) begin
                t = (part == 0) ? vr[r] : vi[r];
                t = (sh > 0) ? ((t + (64'sd1 <<< (sh - 1))) >>> sh) : (t <<< (-sh));
                if (t > 127) t = 127;
                if (t < -128) t = -128;
                if (part == 0) nxt_re[r] = int'(t); else nxt_im[r] = int'(t);
            end
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            for (int k = 0; k < 4; k++) begin m_out_re[k] = 0; m_out_im[k] = 0; end
            for (int k = 0; k < 16; k++) begin mem_re[k] = 0; mem_im[k] = 0; end
        end else if (!m_busy) begin
            if (in_we) begin mem_re[in_addr] = int'(in_re); mem_im[in_addr] = int'(in_im); end
            if (start) begin compute_ref(); m_busy = 1; m_cnt = 1; m_done = 0; end
        end else begin
            if (m_cnt == LAT) begin
                m_busy = 0; m_done = 0;
            end else begin
                m_cnt++;
                if (m_cnt == LAT) begin
                    m_done = 1;
                    for (int k = 0; k < 4; k++) begin m_out_re[k] = nxt_re[k]; m_out_im[k] = nxt_im[k]; end
                end
            end
        end
    end

    task automatic check_val(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !finished) begin
            check_val("R7", "busy", int'(busy), int'(m_busy));
            check_val("R7", "done", int'(done), int'(m_done));
            if (!m_busy || m_done) begin
                check_val(cur_req, "out_re", int'(out_re), m_out_re[out_addr]);
                check_val(cur_req, "out_im", int'(out_im), m_out_im[out_addr]);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic load_stim();
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            in_we = 1; in_addr = 4'(k); in_re = 8'(stim_re[k]); in_im = 8'(stim_im[k]);
        end
        @(negedge clk);
        in_we = 0;
    endtask

    task automatic clear_stim();
        for (int k = 0; k < 16; k++) begin stim_re[k] = 0; stim_im[k] = 0; end
    endtask

    task automatic sweep_out();
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); out_addr = 2'(a);
            @(negedge clk);
        end
    endtask

    task automatic run_once();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (LAT + 2) @(negedge clk);
        sweep_out();
    endtask

    task automatic run_vec(input string req);
        cur_req = req;
        load_stim();
        run_once();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state on all four words
        cur_req = "R1";
        sweep_out();

        // R2: single nonzero elements expose the column-wise reshape
        clear_stim(); stim_re[5] = 100;
        run_vec("R2");
        clear_stim(); stim_re[14] = -50; stim_im[14] = 37;
        run_vec("R2");
        clear_stim(); stim_im[3] = 127; stim_re[8] = 3;
        run_vec("R2");

        // R3 / R4: general complex vectors
        for (int n = 0; n < 3; n++) begin
            for (int k = 0; k < 16; k++) begin
                stim_re[k] = int'($urandom_range(0, 255)) - 128;
                stim_im[k] = int'($urandom_range(0, 255)) - 128;
            end
            run_vec((n == 0) ? "R3" : "R4");
        end

        // R5: full-scale negative input, tiny input, zero input
        for (int k = 0; k < 16; k++) begin stim_re[k] = -128; stim_im[k] = -128; end
        run_vec("R5");
        clear_stim(); stim_re[0] = 1; stim_im[6] = -1;
        run_vec("R5");
        clear_stim();
        run_vec("R5");

        // R6: rounding and saturation of the final scale
        for (int k = 0; k < 16; k++) begin
            stim_re[k] = (k % 3 == 0) ? 127 : -(k * 7);
            stim_im[k] = (k % 2 == 0) ? 9 : -128;
        end
        run_vec("R6");

        // R8: start and writes during a run are ignored
        for (int k = 0; k < 16; k++) begin
            stim_re[k] = int'($urandom_range(0, 255)) - 128;
            stim_im[k] = int'($urandom_range(0, 255)) - 128;
        end
        cur_req = "R8";
        load_stim();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            in_we = 1; in_addr = 4'(n); in_re = 8'(n * 11); in_im = -8'(n);
            start = (n % 5 == 0);
        end
        @(negedge clk); in_we = 0; start = 0;
        repeat (LAT) @(negedge clk);
        sweep_out();
        run_once();

        // R9: result held and addressable while idle
        cur_req = "R9";
        for (int n = 0; n < 3; n++) begin
            repeat (5) @(negedge clk);
            sweep_out();
        end

        repeat (3) @(negedge clk);
        summary();
    end

endmodule